// File: doc/BRIEF.md
# Sticky Alert Status Controller

This block gathers level-sensitive out-of-limit conditions from a set of monitoring sources (temperature high and low limits, sensor diode faults, over-temperature shutdown conditions and fan faults) into latched status bits. It drives one active-low alert line, and each source can be kept off that line by its own mask bit. Firmware reaches the block through a plain register port: an address, write data with a write strobe, and a read strobe with registered read data.

A status bit latches on the first cycle its condition is seen and holds it after the condition goes away. Reading the status register that holds the bit clears it, but only if the condition is no longer present. Masking a source keeps it off the alert line, but its status bit still latches. In comparator mode the over-temperature state source drives the alert line straight from its live condition, and its mask bit and latch are bypassed.

Top module: `sac_alert_ctrl`

## Requirements
- R1: A high `cond_*` bit sets its status bit at the next rising clock edge. Status register A (address 0x41) holds `cond_temp[7:0]` at bits 7..0. Status register B (0x42) holds `cond_therm[2]`, `cond_therm[1]` and `cond_therm[0]` at bits 4, 3 and 2. Status register C (0x43) holds `cond_fan[2]`, `cond_fan[1]` and `cond_fan[0]` at bits 7, 6 and 5.
- R2: A set status bit stays set after its condition goes low, for as long as its status register is not read.
- R3: A read of a status register (`rd_en` high at the edge) puts the register's content before the read on `rdata` after that edge. The same edge clears every bit of that register whose condition is low.
- R4: A bit whose condition is high at the edge of a read stays set after the read. This also holds when the condition rises in the same cycle as the read: the event takes precedence over the clear.
- R5: A mask bit of 1 keeps its source off `alert_n`, but the status bit still latches.
- R6: In interrupt mode (`cmp_mode` = 0), `alert_n` is 0 exactly while some status bit is set and its mask bit is 0. It returns to 1 once every unmasked status bit is clear, whether a read cleared the bit or a mask bit was set.
- R7: Mask registers A, B and C sit at addresses 0x08, 0x09 and 0x0A. Each mask bit shares its position with the status bit it gates. All mask bits are 0 after reset, and a written value reads back.
- R8: Status bits with no source, and mask bits with no source (mask B bits 7,6,5,1,0; mask C bits 4..0), read as 0, and writes to them are ignored. Writes to status addresses change nothing.
- R9: With `cmp_mode` = 1, the state source (`cond_therm[0]`) pulls `alert_n` low for exactly the cycles its condition is high, whatever mask B bit 2 and its status bit hold.
- R10: A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_temp | input | 8 | Temperature conditions: local high/low, remote-1 high/low/diode, remote-2 high/low/diode |
| cond_therm | input | 3 | Over-temperature conditions: on-time percentage, limit exceeded, state |
| cond_fan | input | 3 | Fan conditions: fan 1 stall, alarm speed, fan 2 stall |
| cmp_mode | input | 1 | 1 selects comparator mode for the state source |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| alert_n | output | 1 | Alert line, active low |

## Verification
The bench reads a status register while its condition is still high, and again with the condition rising in the same cycle as the read. A design that cleared on every read would lose the bit in both cases. It masks a latched source and confirms that the status bit latches while the alert line releases. A design that gated the latch with the mask would lose the record of the event, and one that ignored the mask would hold the line low. Comparator mode is run with the state source masked and its latch still set, which shows that the line follows only the live condition. The bench also writes ones into reserved and status positions and reads back zeros, which exposes a register that keeps bits with no source.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 8;
  localparam int NUM_GRP = 3;

  localparam logic [ADDR_W-1:0] STAT_BASE = 8'h41;
  localparam logic [ADDR_W-1:0] MASK_BASE = 8'h08;

  // group and bit of the over-temperature state source
  localparam int STATE_GRP = 1;
  localparam int STATE_BIT = 2;

  typedef logic [NUM_GRP-1:0][REG_W-1:0] grp_vec_t;

  function automatic logic [REG_W-1:0] impl_bits(int grp);
    case (grp)
      0:       impl_bits = 8'hFF;
      1:       impl_bits = 8'h1C;
      2:       impl_bits = 8'hE0;
      default: impl_bits = 8'h00;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] stat_addr(int grp);
    stat_addr = STAT_BASE + ADDR_W'(grp);
  endfunction

  function automatic logic [ADDR_W-1:0] mask_addr(int grp);
    mask_addr = MASK_BASE + ADDR_W'(grp);
  endfunction
endpackage

// File: rtl/sac_sticky_bank.sv
module sac_sticky_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic         rd_clr,
  output logic [W-1:0] status
);
  logic [W-1:0] stat_q;

  // a live condition always reasserts, so an event beats a same-cycle read
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (cond | (stat_q & ~{W{rd_clr}})) & IMPL;
  end

  assign status = stat_q;
endmodule

// File: rtl/sac_mask_reg.sv
module sac_mask_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  mask_q <= '0;
    else if (wr) mask_q <= wdata & IMPL;
  end

  assign mask = mask_q;
endmodule

// File: rtl/sac_decode.sv
module sac_decode
  import sac_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic               rd_en,
  output logic [NUM_GRP-1:0] stat_sel,
  output logic [NUM_GRP-1:0] mask_sel,
  output logic [NUM_GRP-1:0] stat_rd,
  output logic [NUM_GRP-1:0] mask_wr
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
    assign stat_sel[g] = (addr == stat_addr(g));
    assign mask_sel[g] = (addr == mask_addr(g));
    assign stat_rd[g]  = rd_en & stat_sel[g];
    assign mask_wr[g]  = wr_en & mask_sel[g];
  end
endmodule

// File: rtl/sac_alert_merge.sv
module sac_alert_merge
  import sac_pkg::*;
(
  input  grp_vec_t stat,
  input  grp_vec_t mask,
  input  logic     cmp_mode,
  input  logic     state_live,
  output logic     alert_n
);
  grp_vec_t pend;

  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) pend[g] = stat[g] & ~mask[g];
    // in comparator mode the state source bypasses its latch and mask
    if (cmp_mode) pend[STATE_GRP][STATE_BIT] = state_live;
  end

  assign alert_n = ~(|pend);
endmodule

// File: rtl/sac_alert_ctrl.sv
module sac_alert_ctrl
  import sac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cond_temp,
  input  logic [2:0]        cond_therm,
  input  logic [2:0]        cond_fan,
  input  logic              cmp_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rdata,
  output logic              alert_n
);
  grp_vec_t cond_b, stat_b, mask_b;
  logic [NUM_GRP-1:0] stat_sel, mask_sel, stat_rd, mask_wr;
  logic [REG_W-1:0]   rd_val, rdata_q;

  assign cond_b[0] = cond_temp;
  assign cond_b[1] = {3'b000, cond_therm, 2'b00};
  assign cond_b[2] = {cond_fan, 5'b00000};

  sac_decode u_dec (
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .stat_sel (stat_sel),
    .mask_sel (mask_sel),
    .stat_rd  (stat_rd),
    .mask_wr  (mask_wr)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    sac_sticky_bank #(.W(REG_W), .IMPL(impl_bits(g))) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond   (cond_b[g]),
      .rd_clr (stat_rd[g]),
      .status (stat_b[g])
    );
    sac_mask_reg #(.W(REG_W), .IMPL(impl_bits(g))) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (mask_wr[g]),
      .wdata (wdata),
      .mask  (mask_b[g])
    );
  end

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (stat_sel[g]) rd_val = rd_val | stat_b[g];
      if (mask_sel[g]) rd_val = rd_val | mask_b[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_val;
  end

  assign rdata = rdata_q;

  sac_alert_merge u_merge (
    .stat       (stat_b),
    .mask       (mask_b),
    .cmp_mode   (cmp_mode),
    .state_live (cond_therm[0]),
    .alert_n    (alert_n)
  );
endmodule

// File: rtl/sac_checker.sv
module sac_checker
  import sac_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input grp_vec_t           cond_all,
  input grp_vec_t           stat_all,
  input grp_vec_t           mask_all,
  input logic [NUM_GRP-1:0] rd_clr,
  input logic               cmp_mode,
  input logic               state_live,
  input logic               alert_n
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_all[g] & ($past(cond_all[g]) & impl_bits(g))) ==
                ($past(cond_all[g]) & impl_bits(g))));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr[g] |=> ((stat_all[g] & $past(stat_all[g])) == $past(stat_all[g])));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr[g] |=> (stat_all[g] == ($past(cond_all[g]) & impl_bits(g))));

    assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_all[g] | mask_all[g]) & ~impl_bits(g)) == '0);

    assert_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_mode && ((stat_all[g] & ~mask_all[g]) != '0)) |-> !alert_n);
  end

  assert_cmp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && state_live) |-> !alert_n);
endmodule

bind sac_alert_ctrl sac_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cond_all   (cond_b),
  .stat_all   (stat_b),
  .mask_all   (mask_b),
  .rd_clr     (stat_rd),
  .cmp_mode   (cmp_mode),
  .state_live (cond_therm[0]),
  .alert_n    (alert_n)
);

// File: tb/sac_alert_ctrl_test.sv
module sac_alert_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cond_temp = '0;
  logic [2:0] cond_therm = '0;
  logic [2:0] cond_fan = '0;
  logic       cmp_mode = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       alert_n;
  int n_run = 0;
  int n_fail = 0;
  logic [7:0] v;

  localparam logic [7:0] ST_A = 8'h41, ST_B = 8'h42, ST_C = 8'h43;
  localparam logic [7:0] MK_A = 8'h08, MK_B = 8'h09, MK_C = 8'h0A;

  always #2 clk = ~clk;

  sac_alert_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cond_temp(cond_temp), .cond_therm(cond_therm),
    .cond_fan(cond_fan), .cmp_mode(cmp_mode), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .alert_n(alert_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic drain();
    cond_temp = '0; cond_therm = '0; cond_fan = '0;
    tick();
    reg_rd(ST_A, v); reg_rd(ST_B, v); reg_rd(ST_C, v);
  endtask

  task automatic t_reset();
    reg_rd(ST_A, v); check("R1 reset status A", v, 8'h00);
    reg_rd(MK_A, v); check("R7 reset mask A", v, 8'h00);
    reg_rd(MK_C, v); check("R7 reset mask C", v, 8'h00);
    check("R6 reset alert", {7'b0, alert_n}, 8'h01);
  endtask

  task automatic t_sticky();
    cond_temp = 8'h24; cond_therm = 3'b110; cond_fan = 3'b101;
    tick();
    check("R6 alert asserted", {7'b0, alert_n}, 8'h00);
    cond_temp = '0; cond_therm = '0; cond_fan = '0;
    tick(); tick();
    reg_rd(ST_A, v); check("R2 status A held", v, 8'h24);
    reg_rd(ST_B, v); check("R1 status B layout", v, 8'h18);
    reg_rd(ST_C, v); check("R1 status C layout", v, 8'hA0);
    reg_rd(ST_A, v); check("R3 status A cleared", v, 8'h00);
    check("R6 alert released", {7'b0, alert_n}, 8'h01);
  endtask

  task automatic t_active_read();
    cond_temp = 8'h81;
    tick();
    cond_temp = 8'h80;
    reg_rd(ST_A, v); check("R3 read content", v, 8'h81);
    reg_rd(ST_A, v); check("R4 active bit kept", v, 8'h80);
    cond_temp = 8'h00;
    reg_rd(ST_A, v); check("R3 cleared after drop", v, 8'h80);
    reg_rd(ST_A, v); check("R3 empty", v, 8'h00);
  endtask

  task automatic t_same_cycle();
    cond_fan = 3'b010;
    reg_rd(ST_C, v); check("R4 read before event", v, 8'h00);
    cond_fan = 3'b000;
    reg_rd(ST_C, v); check("R4 event beats read", v, 8'h40);
    reg_rd(ST_C, v); check("R4 later clear", v, 8'h00);
  endtask

  task automatic t_mask();
    reg_wr(MK_A, 8'h10);
    reg_rd(MK_A, v); check("R7 mask A readback", v, 8'h10);
    cond_temp = 8'h10;
    tick();
    check("R5 masked no alert", {7'b0, alert_n}, 8'h01);
    cond_temp = 8'h00;
    reg_rd(ST_A, v); check("R5 masked still latches", v, 8'h10);
    cond_temp = 8'h02;
    tick();
    cond_temp = 8'h00;
    check("R6 unmasked alerts", {7'b0, alert_n}, 8'h00);
    reg_wr(MK_A, 8'h12);
    check("R6 release by mask", {7'b0, alert_n}, 8'h01);
    reg_rd(ST_A, v); check("R6 status kept under mask", v, 8'h02);
    reg_wr(MK_A, 8'h00);
    check("R6 cleared stays quiet", {7'b0, alert_n}, 8'h01);
  endtask

  task automatic t_reserved();
    reg_wr(MK_B, 8'hFF); reg_rd(MK_B, v); check("R8 mask B reserved", v, 8'h1C);
    reg_wr(MK_C, 8'hFF); reg_rd(MK_C, v); check("R8 mask C reserved", v, 8'hE0);
    reg_wr(MK_B, 8'h00); reg_wr(MK_C, 8'h00);
    reg_wr(ST_A, 8'hFF); reg_rd(ST_A, v); check("R8 status not writable", v, 8'h00);
    check("R8 no alert after write", {7'b0, alert_n}, 8'h01);
    reg_wr(8'h55, 8'hFF); reg_rd(8'h55, v); check("R10 unmapped read", v, 8'h00);
  endtask

  task automatic t_cmp();
    reg_wr(MK_B, 8'h04);
    cmp_mode = 1'b1;
    cond_therm = 3'b001;
    tick();
    check("R9 live state alerts", {7'b0, alert_n}, 8'h00);
    cond_therm = 3'b000;
    tick();
    check("R9 follows live low", {7'b0, alert_n}, 8'h01);
    reg_rd(ST_B, v); check("R9 status latched", v, 8'h04);
    reg_wr(MK_B, 8'h00);
    cond_therm = 3'b001; tick(); cond_therm = 3'b000; tick();
    check("R9 latch ignored in cmp", {7'b0, alert_n}, 8'h01);
    cmp_mode = 1'b0;
    tick();
    check("R6 latch alerts in int mode", {7'b0, alert_n}, 8'h00);
    reg_rd(ST_B, v);
    check("R6 released after read", {7'b0, alert_n}, 8'h01);
  endtask

  initial begin
    fork
      begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sticky();
        drain();
        t_active_read();
        t_same_cycle();
        t_mask();
        drain();
        t_reserved();
        t_cmp();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule